// File: doc/BRIEF.md
# Stream Input Register Channel

A one-slot operand register that sits between a single fixed upstream producer and the operand-selection logic of a processing element. The producer can be one neighbouring element or one incoming memory line. Nothing else can write the slot, because the block has exactly one source port. The producer offers a word with a valid strobe. The slot takes it only when its own wait flag is low.

Once a word is captured, the slot raises an operand-available flag to the local decoder and holds wait high toward the producer. It keeps doing so until the decoder pulses a read strobe. Each word is therefore delivered exactly once. The consume edge clears the registered occupancy flag, so the slot can take the next word no earlier than the edge after that. Two words sent back to back to the same slot are thus spaced by at least one idle cycle.

The data width is a parameter, 32 bits by default for single-precision operands and 64 for double. A second parameter chooses whether the operand output shows zero or the stale word while the slot is empty.

Top module: `stream_in_reg`

## Requirements
- R1: A synchronous active-high reset leaves the slot empty: `opnd_avail` = 0, `src_wait` = 0 and, with `ZERO_WHEN_EMPTY` = 1, `opnd_data` = 0 from the first clock edge with reset high.
- R2: At a rising edge where `src_valid` = 1 and `src_wait` = 0, `src_data` is captured; after that edge `opnd_avail` = 1 and `opnd_data` equals the captured word.
- R3: At an edge where `src_valid` = 0 and the slot is empty, nothing is captured and `opnd_avail` stays 0.
- R4: While the slot holds a word, `src_wait` = 1 and any offered word is refused: `opnd_data` keeps the held word and `opnd_avail` stays 1 until a read strobe.
- R5: At an edge where `rd_strobe` = 1 and the slot is full, the word is consumed; after that edge `opnd_avail` = 0 and `src_wait` = 0.
- R6: `rd_strobe` while the slot is empty has no effect: the slot stays empty and a word offered at the same edge is still captured normally.
- R7: A consumed word is delivered once only: after consumption, further read strobes leave `opnd_avail` at 0 until a new word is captured.
- R8: When a producer keeps a new word valid across a consume edge, that word is accepted at the following edge at the earliest, so `opnd_avail` reads 0 for exactly one cycle between the two words.
- R9: `src_wait` and `opnd_avail` are both the registered occupancy flag. They rise only after a capture edge, and they are equal in every cycle.
- R10: With `ZERO_WHEN_EMPTY` = 1, `opnd_data` is 0 in every cycle where `opnd_avail` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 1 | Producer offers a word |
| src_data | input | WIDTH | Offered word |
| src_wait | output | 1 | Slot occupied; producer must hold off |
| rd_strobe | input | 1 | Decoder consumes the held word |
| opnd_avail | output | 1 | Slot holds an unread word |
| opnd_data | output | WIDTH | Held word (zero while empty when so configured) |

## Verification
The bench targets the cases where a word is offered while the slot is full. A design that ignored wait there would overwrite the held word, which shows up as a changed `opnd_data` before any read strobe. It strobes an empty slot, alone and together with a fresh offer. A design that decoded the strobe without checking occupancy would drop the new word or wrap the flag. It holds an offer across a consume edge to confirm the one idle cycle; an unregistered wait path would take the new word at once with no gap. Random traffic then checks the occupancy flag, both handshake outputs and the zero masking against a bench model on every cycle.

// File: rtl/stream_in_reg_pkg.sv
package stream_in_reg_pkg;
   typedef enum logic {
      SLOT_EMPTY = 1'b0,
      SLOT_HELD  = 1'b1
   } slot_state_e;
endpackage

// File: rtl/stream_in_reg_occ.sv
module stream_in_reg_occ
   import stream_in_reg_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic offer,
   input  logic take,
   output logic load,
   output logic held
);
   slot_state_e state_q;
   slot_state_e state_d;
   logic        consume;

   assign held    = (state_q == SLOT_HELD);
   assign load    = offer && !held;
   assign consume = take && held;

   always_comb begin
      state_d = state_q;
      if (load)
         state_d = SLOT_HELD;
      else if (consume)
         state_d = SLOT_EMPTY;
   end

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= SLOT_EMPTY;
      else
         state_q <= state_d;
   end

   p_capture_r2: assert property (@(posedge clk) disable iff (rst)
      offer && !held |=> held);
   p_idle_r3: assert property (@(posedge clk) disable iff (rst)
      !offer && !held |=> !held);
   p_consume_r5: assert property (@(posedge clk) disable iff (rst)
      take && held |=> !held);
   p_rise_needs_offer_r9: assert property (@(posedge clk) disable iff (rst)
      !held && !offer |=> !$rose(held));
endmodule

// File: rtl/stream_in_reg_hold.sv
module stream_in_reg_hold #(
   parameter int WIDTH           = 32,
   parameter bit ZERO_WHEN_EMPTY = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             held,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] word_q;

   always_ff @(posedge clk) begin
      if (rst)
         word_q <= '0;
      else if (load)
         word_q <= din;
   end

   generate
      if (ZERO_WHEN_EMPTY) begin : g_mask
         assign dout = held ? word_q : '0;
      end else begin : g_raw
         assign dout = word_q;
      end
   endgenerate

   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(word_q));
   p_load_r2: assert property (@(posedge clk) disable iff (rst)
      load |=> (word_q == $past(din)));
endmodule

// File: rtl/stream_in_reg.sv
module stream_in_reg #(
   parameter int WIDTH           = 32,
   parameter bit ZERO_WHEN_EMPTY = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             src_valid,
   input  logic [WIDTH-1:0] src_data,
   output logic             src_wait,
   input  logic             rd_strobe,
   output logic             opnd_avail,
   output logic [WIDTH-1:0] opnd_data
);
   localparam int BYTES = (WIDTH + 7) / 8;

   generate
      if (WIDTH < 1 || WIDTH > 128) begin : g_bad_width
         $error("stream_in_reg: WIDTH out of range");
      end
      if (BYTES * 8 != WIDTH && WIDTH > 8) begin : g_odd_width
         $info("stream_in_reg: WIDTH is not a whole number of bytes");
      end
   endgenerate

   logic load;
   logic held;

   stream_in_reg_occ u_occ (
      .clk   (clk),
      .rst   (rst),
      .offer (src_valid),
      .take  (rd_strobe),
      .load  (load),
      .held  (held)
   );

   stream_in_reg_hold #(
      .WIDTH           (WIDTH),
      .ZERO_WHEN_EMPTY (ZERO_WHEN_EMPTY)
   ) u_hold (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .held (held),
      .din  (src_data),
      .dout (opnd_data)
   );

   assign src_wait   = held;
   assign opnd_avail = held;

   p_refuse_r4: assert property (@(posedge clk) disable iff (rst)
      src_wait && !rd_strobe |=> opnd_avail && $stable(opnd_data));
   p_once_r7: assert property (@(posedge clk) disable iff (rst)
      !opnd_avail && !src_valid |=> !opnd_avail);
   p_gap_r8: assert property (@(posedge clk) disable iff (rst)
      opnd_avail && rd_strobe |=> !src_wait);
   p_mask_r10: assert property (@(posedge clk) disable iff (rst)
      !opnd_avail && ZERO_WHEN_EMPTY |-> opnd_data == '0);
endmodule

// File: tb/stream_in_reg_bench.sv
module stream_in_reg_bench;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst;
   logic         src_valid;
   logic [W-1:0] src_data;
   logic         src_wait;
   logic         rd_strobe;
   logic         opnd_avail;
   logic [W-1:0] opnd_data;

   int n_vec  = 0;
   int n_fail = 0;

   logic         m_full;
   logic [W-1:0] m_word;

   always #10 clk = ~clk;

   stream_in_reg #(.WIDTH(W), .ZERO_WHEN_EMPTY(1'b1)) u_stream_in_reg (
      .clk        (clk),
      .rst        (rst),
      .src_valid  (src_valid),
      .src_data   (src_data),
      .src_wait   (src_wait),
      .rd_strobe  (rd_strobe),
      .opnd_avail (opnd_avail),
      .opnd_data  (opnd_data)
   );

   function automatic logic [W-1:0] exp_data(logic full, logic [W-1:0] word);
      return full ? word : '0;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      check(opnd_avail == m_full, {req, " avail"}, 64'(opnd_avail), 64'(m_full));
      check(src_wait == m_full, {req, " R9 wait"}, 64'(src_wait), 64'(m_full));
      check(opnd_data == exp_data(m_full, m_word), {req, " R10 data"},
            64'(opnd_data), 64'(exp_data(m_full, m_word)));
   endtask

   // drive at negedge, model the coming posedge, sample at next negedge
   task automatic step(input logic v, input logic [W-1:0] d, input logic r);
      src_valid = v;
      src_data  = d;
      rd_strobe = r;
      if (v && !m_full) begin
         m_full = 1'b1;
         m_word = d;
      end else if (r && m_full) begin
         m_full = 1'b0;
      end
      @(negedge clk);
   endtask

   initial begin
      #4000000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst = 1'b1; src_valid = 1'b1; src_data = 32'hDEAD_BEEF; rd_strobe = 1'b0;
      m_full = 1'b0; m_word = '0;
      repeat (3) @(negedge clk);
      check_all("R1");
      rst = 1'b0;
      src_valid = 1'b0;
      @(negedge clk);
      check_all("R1");

      step(1'b0, 32'h1111_1111, 1'b0); check_all("R3");
      step(1'b1, 32'h3F80_0000, 1'b0); check_all("R2");
      step(1'b1, 32'h4000_0000, 1'b0); check_all("R4");
      step(1'b1, 32'h4040_0000, 1'b0); check_all("R4");
      step(1'b0, '0, 1'b1);            check_all("R5");
      step(1'b0, '0, 1'b1);            check_all("R7");
      step(1'b1, 32'hC0A0_0000, 1'b1); check_all("R6");
      check(opnd_data == 32'hC0A0_0000, "R6 word", 64'(opnd_data), 64'hC0A0_0000);
      // R8: offer held across consume edge
      step(1'b1, 32'h4110_0000, 1'b1); check_all("R8");
      check(opnd_avail == 1'b0, "R8 gap", 64'(opnd_avail), 64'd0);
      step(1'b1, 32'h4110_0000, 1'b0); check_all("R8");
      check(opnd_avail == 1'b1, "R8 next", 64'(opnd_avail), 64'd1);

      for (int i = 0; i < 3000; i++) begin
         logic v, r;
         v = ($urandom % 4) != 0;
         r = ($urandom % 3) == 0;
         step(v, $urandom, r);
         check_all("R2 R4 R5 random");
      end

      rst = 1'b1; m_full = 1'b0; m_word = '0;
      @(negedge clk);
      check_all("R1");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule